// File: doc/BRIEF.md
# Interval-Measuring Capture Timer

This block counts cycles of its own clock between consecutive pulses on an event input. Each accepted event stores the length of the interval that just ended in a capture register. In the same cycle the running count restarts, so every stored value is the distance between two neighbouring events and not a free-running timestamp. A typical use is to measure a slow reference tick against a precise clock. Software then corrects a timebase from the measured cycle count.

The counter is 16 bits wide by default and runs on the measurement clock without a prescaler. A captured value is therefore the interval taken modulo 2^16. A sticky wrap flag shows that the running count rolled over since the last capture. Software can use it to add the missing multiple of 65536 when the expected interval is longer than the counter range. A sticky capture-valid flag works as an interrupt request and stays high until it is cleared explicitly.

Top module: `interval_timer`

## Requirements
- R1: While rst_ni is low, cap_o is 0, cap_vld_o is 0 and wrap_o is 0.
- R2: An event is accepted on a rising edge when en_i, cap_en_i and evt_i are all 1. At that edge cap_o takes the number of enabled edges since the previous accepted event (or since reset), counting the accepting edge itself, modulo 65536. The running count restarts in the same edge.
- R3: An event with cap_en_i = 0 is ignored. cap_o and cap_vld_o do not change, and the running interval is not restarted.
- R4: While en_i = 0 the count holds and events are ignored. Disabled edges do not add to the next captured interval.
- R5: cap_vld_o goes to 1 on each accepted event and stays 1 until an edge with irq_clr_i = 1 and no accepted event clears it.
- R6: An accepted event and irq_clr_i = 1 on the same edge leave cap_vld_o at 1.
- R7: wrap_o goes to 1 when the running count rolls from 65535 to 0 by counting, and goes to 0 on each accepted event. An interval of 70000 edges captures 4464. An interval of exactly 65536 edges captures 0 and does not set wrap_o.
- R8: Events on two consecutive edges capture the value 1 at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| cap_en_i | input | 1 | Event capture enable |
| evt_i | input | 1 | Single-cycle event strobe, synchronous to clk_i |
| irq_clr_i | input | 1 | Clears cap_vld_o |
| cap_o | output | 16 | Last captured interval |
| cap_vld_o | output | 1 | Sticky capture-valid interrupt flag |
| wrap_o | output | 1 | Count rolled over since the last capture |

## Verification
Two pairs of functions can fall on the same edge, and each pair has its own collision:

- **Capture and flag clear.** The bench drives an event and irq_clr_i together. It expects cap_vld_o still high after that edge, and low only after a later clear that comes without an event.
- **Restart and wrap.** An interval of exactly 65536 edges lands the accepting edge on a count of 65535. The expected result is a capture of 0 with wrap_o remaining low.

Back-to-back events on adjacent edges check that the restart and the next count line up to give a capture of 1.

// File: rtl/itv_pkg.sv
package itv_pkg;
  parameter int unsigned ITV_W_DEF = 16;

  function automatic logic evt_take(input logic en, input logic cap_en, input logic evt);
    return en & cap_en & evt;
  endfunction
endpackage

// File: rtl/itv_counter.sv
module itv_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         acc_i,
  output logic [W-1:0] len_o,
  output logic         roll_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (acc_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  // interval length includes the current edge
  assign len_o  = cnt_q + 1'b1;
  assign roll_o = en_i & ~acc_i & (cnt_q == CNT_MAX);

  // R4
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R2
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (cnt_q == '0));
endmodule

// File: rtl/itv_capture.sv
module itv_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_i,
  input  logic         clr_i,
  input  logic         roll_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cap_o,
  output logic         vld_o,
  output logic         wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o  <= '0;
      vld_o  <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      if (acc_i) cap_o <= len_i;
      vld_o  <= acc_i | (vld_o & ~clr_i);
      wrap_o <= ~acc_i & (wrap_o | roll_i);
    end
  end

  // R3
  cap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(cap_o));
  // R5
  vld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !clr_i) |=> vld_o);
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> vld_o);
  // R7
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !wrap_o);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned CNT_W = itv_pkg::ITV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cap_en_i,
  input  logic             evt_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_vld_o,
  output logic             wrap_o
);
  logic             acc;
  logic             roll;
  logic [CNT_W-1:0] len;

  assign acc = itv_pkg::evt_take(en_i, cap_en_i, evt_i);

  itv_counter #(.W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .acc_i  (acc),
    .len_o  (len),
    .roll_o (roll)
  );

  itv_capture #(.W(CNT_W)) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .clr_i  (irq_clr_i),
    .roll_i (roll),
    .len_i  (len),
    .cap_o  (cap_o),
    .vld_o  (cap_vld_o),
    .wrap_o (wrap_o)
  );

  // R3
  gated_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !cap_en_i && !cap_vld_o && !irq_clr_i) |=> !cap_vld_o);
  // R4
  off_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> $stable(cap_o));
endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, cap_en_i = 1'b0, evt_i = 1'b0;
  logic        mon_clr = 1'b0, dir_clr = 1'b0;
  logic        irq_clr_i;
  logic [15:0] cap_o;
  logic        cap_vld_o, wrap_o;

  assign irq_clr_i = mon_clr | dir_clr;

  interval_timer i_interval_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cap_en_i(cap_en_i),
    .evt_i(evt_i), .irq_clr_i(irq_clr_i), .cap_o(cap_o),
    .cap_vld_o(cap_vld_o), .wrap_o(wrap_o)
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int run = 0;
  int last_exp = 0;
  bit wrap_exp = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // one posedge with the given inputs; expected interval derived from R2/R4/R7
  task automatic step(bit en, bit ce, bit ev, bit clr);
    en_i = en; cap_en_i = ce; evt_i = ev; dir_clr = clr;
    if (en && ce && ev) begin
      last_exp = (run + 1) % 65536;
      if (mon_on) exp_q.push_back(last_exp);
      run = 0;
      wrap_exp = 1'b0;
    end else if (en) begin
      if (run % 65536 == 65535) wrap_exp = 1'b1;
      run++;
    end
    @(negedge clk_i);
  endtask

  // monitor: pops expected captures as cap_vld_o appears, then clears
  always @(negedge clk_i) begin
    if (mon_clr) mon_clr = 1'b0;
    else if (mon_on && cap_vld_o) begin
      if (exp_q.size() == 0) chk("R2 unexpected capture", 1, 0);
      else chk("R2 captured interval", int'(cap_o), exp_q.pop_front());
      mon_clr = 1'b1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 cap_o in reset", int'(cap_o), 0);
    chk("R1 cap_vld_o in reset", int'(cap_vld_o), 0);
    chk("R1 wrap_o in reset", int'(wrap_o), 0);
    rst_ni = 1'b1;
    run = 0;
    mon_on = 1'b1;

    // R2 several intervals
    repeat (10) step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    repeat (4) step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    repeat (36) step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    step(1, 1, 0, 0);
    step(1, 1, 1, 0);

    // R3 event with capture disabled
    repeat (4) step(1, 1, 0, 0);
    step(1, 0, 1, 0);
    chk("R3 gated event sets no flag", int'(cap_vld_o), 0);
    repeat (3) step(1, 1, 0, 0);
    step(1, 1, 1, 0);

    // R4 counter disabled, events ignored
    repeat (3) step(1, 1, 0, 0);
    repeat (5) step(0, 1, 1, 0);
    chk("R4 event while disabled sets no flag", int'(cap_vld_o), 0);
    repeat (2) step(1, 1, 0, 0);
    step(1, 1, 1, 0);

    // R7 long interval rolls over
    repeat (69999) step(1, 1, 0, 0);
    chk("R7 wrap_o after rollover", int'(wrap_o), int'(wrap_exp));
    step(1, 1, 1, 0);
    step(1, 1, 0, 0);
    chk("R7 wrap_o cleared by capture", int'(wrap_o), 0);

    // R7 exactly 65536: capture 0, no wrap
    repeat (65534) step(1, 1, 0, 0);
    chk("R7 no wrap before 65536th edge", int'(wrap_o), 0);
    step(1, 1, 1, 0);
    step(1, 1, 0, 0);
    chk("R7 wrap_o low after 65536 interval", int'(wrap_o), 0);

    repeat (4) step(1, 1, 0, 0);
    chk("R2 all captures seen", exp_q.size(), 0);
    mon_on = 1'b0;
    step(1, 1, 0, 0);
    chk("R5 flag low after monitor clear", int'(cap_vld_o), 0);

    // directed: R5, R6, R8
    step(1, 1, 1, 0);
    chk("R5 flag set by capture", int'(cap_vld_o), 1);
    chk("R2 directed capture", int'(cap_o), last_exp);
    step(1, 1, 0, 0);
    chk("R5 flag held without clear", int'(cap_vld_o), 1);
    step(1, 1, 1, 0);
    step(1, 1, 1, 1);
    chk("R8 adjacent events capture 1", int'(cap_o), 1);
    chk("R6 capture beats clear", int'(cap_vld_o), 1);
    step(1, 1, 0, 1);
    chk("R5 lone clear drops flag", int'(cap_vld_o), 0);
    step(1, 1, 0, 0);
    chk("R5 flag stays low", int'(cap_vld_o), 0);
    chk("R3 capture register unchanged", int'(cap_o), 1);

    finish_run();
  end
endmodule